// File: doc/BRIEF.md
# Per-Pin Input Interrupt Detector

This block turns a set of sampled input words into interrupt requests. The inputs are grouped into banks of 32 pins. Pin p of bank b carries the global number b*32+p and sits at bit p of that bank's words. A new copy of every input word arrives once per frame, marked by a one-cycle strobe. For each pin, the block keeps a trigger configuration, an enable and a sticky status bit. A single interrupt line is high while any enabled status bit in any bank is set.

Each pin's trigger mode is spread over three configuration words: polarity (`pol`), level select (`lvl`) and dual-edge select (`dual`). With `lvl`=0 the pin is edge-sensitive: `pol`=0 catches falling edges and `pol`=1 catches rising edges. Setting `dual`=1 on an edge-sensitive pin catches both edges. With `lvl`=1 the pin is level-sensitive: `pol` chooses active-high (1) or active-low (0). Software clears a status bit by writing a one to it. The sample input is a plain strobe. The block accepts every frame in the cycle it arrives and never pushes back, so there is no ready signal.

Register access uses a simple write port and a combinational read port, both addressed by bank index and a 3-bit selector. The selector codes are: 0 enable, 1 `pol`, 2 `lvl`, 3 `dual`, 4 status. Codes 5 to 7 are unused.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every enable, `pol`, `lvl`, `dual` and status word reads 0, and `irq_o` is low. The all-zero configuration means single falling-edge triggering.
- R2: With `lvl`=0 and `dual`=0, a pin compares each accepted sample with the previous accepted sample. `pol`=0 detects a 1-to-0 change and `pol`=1 detects a 0-to-1 change. The first sample accepted after reset produces no edge.
- R3: With `lvl`=0 and `dual`=1, a pin detects both 0-to-1 and 1-to-0 changes, whatever `pol` holds.
- R4: With `lvl`=1, a pin is set on every clock cycle in which its last accepted sample equals its `pol` value. `dual` has no effect in this mode.
- R5: A write to the status selector clears each status bit written as 1 and leaves bits written as 0 unchanged. Such a write never sets a status bit.
- R6: A detected event sets a status bit only while the pin's enable is 1. Clearing an enable leaves the stored status bit as it is.
- R7: `irq_o` is high exactly when some bank has a status bit set whose enable is also set.
- R8: A clear of a level-sensitive pin whose level is still active drops the status bit for one cycle. The bit is set again on the next cycle.
- R9: When an edge event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Selector codes 5 to 7, and bank indices at or above the bank count, read as 0, and writes to them change nothing. The write data is taken directly as the 32-bit word of the addressed bank.
- R11: The stored sample changes only when the strobe `smp_valid` is high. Input data presented without the strobe is not used for detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Frame strobe: `smp_data` holds a new sample this cycle |
| smp_data | input | NUM_BANKS*32 | Sampled inputs; bank b in bits b*32 +: 32 |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | IDX_W | Bank index of the write |
| wr_sel | input | 3 | Register selector of the write |
| wr_data | input | 32 | Write data (write-one-to-clear for status) |
| rd_bank | input | IDX_W | Bank index of the read |
| rd_sel | input | 3 | Register selector of the read |
| rd_data | output | 32 | Selected register word, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A falling step, a rising step and a fall followed by a rise are each applied to pins in every edge mode. This shows that each mode reacts only to its own direction, and that a dual-edge pin reacts to both. Level-sensitive pins are held active across a clear and then released, which separates the behaviour of a live level from that of a stale status bit. Further tests apply a clear and an edge in the same cycle, change the input data with the strobe low, and send the very first frame after reset. These pin down set priority, strobe qualification and the suppression of the first edge. Disabling a pin with pending status separates masking of the output from the stored status.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BANK_W = 32;
  typedef logic [BANK_W-1:0] word_t;

  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_POL  = 3'd1,
    SEL_LVL  = 3'd2,
    SEL_DUAL = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  word_t pol,
  input  word_t lvl,
  input  word_t dual,
  input  word_t held,
  input  word_t smp_word,
  input  logic  smp_fire,
  input  word_t clr,
  output word_t edge_hit,
  output word_t lvl_hit
);
  for (genvar i = 0; i < BANK_W; i++) begin : g_pin
    logic rise, fall, pick;
    assign rise = smp_fire & smp_word[i] & ~held[i];
    assign fall = smp_fire & ~smp_word[i] & held[i];
    always_comb begin
      if (dual[i])     pick = rise | fall;
      else if (pol[i]) pick = rise;
      else             pick = fall;
    end
    assign edge_hit[i] = ~lvl[i] & pick;
    // level event is held off for the cycle of its own clear
    assign lvl_hit[i]  = lvl[i] & (pol[i] ? held[i] : ~held[i]) & ~clr[i];
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [2:0] wr_sel,
  input  word_t      wr_data,
  input  logic       smp_valid,
  input  word_t      smp_word,
  output word_t      en_o,
  output word_t      pol_o,
  output word_t      lvl_o,
  output word_t      dual_o,
  output word_t      stat_o,
  output logic       irq_o
);
  word_t en_q, pol_q, lvl_q, dual_q, st_q, held_q;
  logic  primed_q;
  word_t clr, edge_hit, lvl_hit, set_vec;

  assign clr = (wr_hit && wr_sel == SEL_STAT) ? wr_data : '0;

  gpio_irq_trig u_trig (
    .pol      (pol_q),
    .lvl      (lvl_q),
    .dual     (dual_q),
    .held     (held_q),
    .smp_word (smp_word),
    .smp_fire (smp_valid & primed_q),
    .clr      (clr),
    .edge_hit (edge_hit),
    .lvl_hit  (lvl_hit)
  );

  assign set_vec = (edge_hit | lvl_hit) & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      lvl_q  <= '0;
      dual_q <= '0;
    end else if (wr_hit) begin
      case (wr_sel)
        SEL_EN:   en_q   <= wr_data;
        SEL_POL:  pol_q  <= wr_data;
        SEL_LVL:  lvl_q  <= wr_data;
        SEL_DUAL: dual_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= '0;
      primed_q <= 1'b0;
    end else if (smp_valid) begin
      held_q   <= smp_word;
      primed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr) | set_vec;
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign lvl_o  = lvl_q;
  assign dual_o = dual_q;
  assign stat_o = st_q;
  assign irq_o  = |(st_q & en_q);

  AST_NO_SET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~$past(st_q) & ~$past(en_q)) == '0)); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((st_q & $past(clr & ~edge_hit & ~lvl_hit)) == '0)); // R5
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_hit & en_q)) |=> ((st_q & $past(edge_hit & en_q)) == $past(edge_hit & en_q))); // R9
  AST_HELD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(held_q)); // R11
  AST_NO_EDGE_BEFORE_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> (edge_hit == '0)); // R2
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_valid,
  input  logic [NUM_BANKS*BANK_W-1:0] smp_data,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_bank,
  input  logic [2:0]                  wr_sel,
  input  logic [BANK_W-1:0]           wr_data,
  input  logic [IDX_W-1:0]            rd_bank,
  input  logic [2:0]                  rd_sel,
  output logic [BANK_W-1:0]           rd_data,
  output logic                        irq_o
);
  word_t en_w   [NUM_BANKS];
  word_t pol_w  [NUM_BANKS];
  word_t lvl_w  [NUM_BANKS];
  word_t dual_w [NUM_BANKS];
  word_t stat_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (int'(wr_bank) == b);
    gpio_irq_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (hit),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .smp_valid (smp_valid),
      .smp_word  (smp_data[b*BANK_W +: BANK_W]),
      .en_o      (en_w[b]),
      .pol_o     (pol_w[b]),
      .lvl_o     (lvl_w[b]),
      .dual_o    (dual_w[b]),
      .stat_o    (stat_w[b]),
      .irq_o     (bank_irq[b])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(rd_bank) == b) begin
        case (rd_sel)
          SEL_EN:   rd_data = en_w[b];
          SEL_POL:  rd_data = pol_w[b];
          SEL_LVL:  rd_data = lvl_w[b];
          SEL_DUAL: rd_data = dual_w[b];
          SEL_STAT: rd_data = stat_w[b];
          default:  rd_data = '0;
        endcase
      end
    end
  end

  assign irq_o = |bank_irq;

  AST_IRQ_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(rst_n)); // R1
endmodule

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  localparam int NB = 3;
  localparam int W  = 32;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [NB*W-1:0] smp_data = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_bank = '0;
  logic [2:0] wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [IW-1:0] rd_bank = '0;
  logic [2:0] rd_sel = '0;
  logic [W-1:0] rd_data;
  logic irq;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NUM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_bank(rd_bank), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq)
  );

  typedef struct {
    logic        is_irq;
    logic [31:0] exp_d;
    logic        exp_irq;
    string       tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    total = 0, bad = 0;
  bit    done = 0;
  logic [31:0] s0 = '1, s1 = '1, s2 = '1;

  // monitor: pops expected items and compares with the design
  initial begin
    item_t it;
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if (it.is_irq) begin
          if (irq !== it.exp_irq) begin
            bad++;
            $display("FAIL %s: irq_o actual=%0b expected=%0b", it.tag, irq, it.exp_irq);
          end
        end else if (rd_data !== it.exp_d) begin
          bad++;
          $display("FAIL %s: rd_data actual=%h expected=%h", it.tag, rd_data, it.exp_d);
        end
      end
    end
  end

  task automatic chk_rd(int b, int s, logic [31:0] e, string tag);
    item_t it;
    rd_bank = IW'(b);
    rd_sel  = 3'(s);
    #1;
    it.is_irq = 1'b0; it.exp_d = e; it.exp_irq = 1'b0; it.tag = tag;
    q.push_back(it);
    ->chk_ev;
    wait (q.size() == 0);
  endtask

  task automatic chk_irq(logic e, string tag);
    item_t it;
    #1;
    it.is_irq = 1'b1; it.exp_d = '0; it.exp_irq = e; it.tag = tag;
    q.push_back(it);
    ->chk_ev;
    wait (q.size() == 0);
  endtask

  task automatic step(logic we, int wb, int ws, logic [31:0] wd, logic sv);
    @(negedge clk);
    wr_en = we; wr_bank = IW'(wb); wr_sel = 3'(ws); wr_data = wd;
    smp_valid = sv; smp_data = {s2, s1, s0};
    @(posedge clk);
  endtask

  task automatic wr(int b, int s, logic [31:0] d);  step(1'b1, b, s, d, 1'b0); endtask
  task automatic idle();                             step(1'b0, 0, 0, '0, 1'b0); endtask
  task automatic frm();                              step(1'b0, 0, 0, '0, 1'b1); endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    s0 = '1; s1 = '1; s2 = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);

    // R1: reset state
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 5; s++) chk_rd(b, s, 32'h0, "R1 reset value");
    chk_irq(1'b0, "R1 irq after reset");

    // R2: bit0 rising, bits 3 and 9 falling, all enabled
    wr(0, 1, 32'h1);
    wr(0, 0, 32'h209);
    frm();                                 // first frame, held was 0
    chk_rd(0, 4, 32'h0, "R2 first sample no edge");
    s0 = 32'hFFFF_FFF7; frm();
    chk_rd(0, 4, 32'h8, "R2 falling edge");
    chk_irq(1'b1, "R7 irq on enabled status");

    // R5: write-one-to-clear
    wr(0, 4, 32'h0);
    chk_rd(0, 4, 32'h8, "R5 zero write keeps status");
    wr(0, 4, 32'h8);
    chk_rd(0, 4, 32'h0, "R5 one write clears");
    chk_irq(1'b0, "R7 irq low with no status");

    s0 = 32'hFFFF_FFF6; frm();
    chk_rd(0, 4, 32'h0, "R2 rising pin ignores fall");
    s0 = 32'hFFFF_FFF7; frm();
    chk_rd(0, 4, 32'h1, "R2 rising edge");

    // R6: masking
    wr(0, 0, 32'h208);
    chk_irq(1'b0, "R6 disable masks irq");
    chk_rd(0, 4, 32'h1, "R6 disable keeps status");
    wr(0, 4, 32'h1);
    s0 = 32'hFFFF_FFE7; frm();             // bit4 falls, not enabled
    chk_rd(0, 4, 32'h0, "R6 masked pin not set");

    // R9: edge and clear in the same cycle
    s0 = 32'hFFFF_FFEF; frm();
    chk_rd(0, 4, 32'h0, "R2 falling pin ignores rise");
    s0 = 32'hFFFF_FFE7; frm();
    chk_rd(0, 4, 32'h8, "R2 falling edge again");
    s0 = 32'hFFFF_FFEF; frm();
    s0 = 32'hFFFF_FFE7; step(1'b1, 0, 4, 32'h8, 1'b1);
    chk_rd(0, 4, 32'h8, "R9 edge wins over clear");
    wr(0, 4, 32'h8);
    chk_rd(0, 4, 32'h0, "R5 clear after collision");

    // R3: both edges on bank1 bit5
    wr(1, 3, 32'h20);
    wr(1, 0, 32'h20);
    s1 = 32'hFFFF_FFDF; frm();
    chk_rd(1, 4, 32'h20, "R3 dual falling");
    chk_irq(1'b1, "R7 irq from bank1");
    wr(1, 4, 32'h20);
    s1 = 32'hFFFF_FFFF; frm();
    chk_rd(1, 4, 32'h20, "R3 dual rising");
    wr(1, 4, 32'h20);

    // R4 / R8: level on bank2 bit7
    wr(2, 1, 32'h80);
    wr(2, 2, 32'h80);
    wr(2, 0, 32'h80);
    idle();
    chk_rd(2, 4, 32'h80, "R4 level high set");
    wr(2, 4, 32'h80);
    chk_rd(2, 4, 32'h0, "R8 cleared for one cycle");
    idle();
    chk_rd(2, 4, 32'h80, "R8 level sets again");
    s2 = 32'hFFFF_FF7F; frm();
    wr(2, 4, 32'h80);
    idle();
    chk_rd(2, 4, 32'h0, "R4 inactive level stays clear");
    wr(2, 1, 32'h0);
    idle();
    chk_rd(2, 4, 32'h80, "R4 level low set");
    wr(2, 3, 32'h80);
    wr(2, 4, 32'h80);
    idle();
    chk_rd(2, 4, 32'h80, "R4 dual ignored in level mode");
    wr(2, 0, 32'h0);
    wr(2, 4, 32'h80);
    idle();
    chk_rd(2, 4, 32'h0, "R6 disabled level pin not set");

    // R11: data without strobe is not sampled
    s0 = 32'hFFFF_FDE7; idle(); idle();
    chk_rd(0, 4, 32'h0, "R11 no strobe no event");
    frm();
    chk_rd(0, 4, 32'h200, "R11 held sample kept until strobe");
    wr(0, 4, 32'h200);

    // R10: unused selectors and banks
    chk_rd(0, 5, 32'h0, "R10 selector 5 reads zero");
    chk_rd(1, 7, 32'h0, "R10 selector 7 reads zero");
    wr(3, 0, 32'hFFFF_FFFF);
    wr(0, 6, 32'hFFFF_FFFF);
    chk_rd(3, 0, 32'h0, "R10 absent bank reads zero");
    chk_rd(0, 0, 32'h208, "R10 bank0 enable untouched");
    chk_rd(1, 0, 32'h20, "R10 bank1 enable untouched");
    chk_rd(2, 0, 32'h0, "R10 bank2 enable untouched");
    chk_rd(0, 4, 32'h0, "R10 bank0 status untouched");
    chk_irq(1'b0, "R7 irq low at end");

    finish_up();
  end
endmodule